// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard and turns them into received bytes. The keyboard owns the serial clock. Both lines are first brought into the system clock domain and filtered for short spikes. Each falling edge of the cleaned keyboard clock then shifts in one bit. After eleven bits the block reports the payload byte. The report is a single-cycle strobe, together with a flag that marks any frame whose start, stop or parity bit is wrong.

A frame that stalls part way through is abandoned once the keyboard clock has been quiet for a programmable number of system cycles. The next falling edge is then taken as a fresh start bit. Downstream logic only needs to watch the strobe. The byte and the flag stay unchanged until the next frame completes.

Top module: `kbd_frame_rx`

## Requirements
- R1: A synchronous reset clears the received byte, the strobe, the error flag and any partly gathered frame, so the first falling edge after reset is a start bit.
- R2: Bits are taken only on falling edges of the filtered keyboard clock. The first bit is the start bit, the next eight are the payload with the least significant bit first, then comes the parity bit, and the eleventh is the stop bit.
- R3: The parity is odd. When the eight payload bits together with the parity bit hold an even number of ones, the error flag is raised with the strobe, and the payload is still reported.
- R4: A start bit of 1 raises the error flag with the strobe.
- R5: A stop bit of 0 raises the error flag with the strobe.
- R6: The strobe is high for exactly one system cycle per completed frame and never at any other time. A well-formed frame gives a clear error flag.
- R7: A pulse on the keyboard clock line that lasts fewer than FILT_LEN system cycles after synchronisation is ignored and shifts no bit.
- R8: If a frame has started and no falling edge arrives for TIMEOUT_CYC system cycles, the partial frame is discarded without a strobe, and the following frame is received correctly.
- R9: The byte and error outputs hold their values from one strobe to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| rx_byte_o | output | 8 | Last received payload byte |
| rx_valid_o | output | 1 | One-cycle strobe on frame completion |
| rx_err_o | output | 1 | Framing or parity error of the last frame |

## Verification
A bit is sampled only after the falling clock has passed the SYNC_STAGES synchroniser flops and FILT_LEN cycles of filtering. One more cycle in the edge detector follows, so the strobe, byte and flag appear SYNC_STAGES + FILT_LEN + 2 system cycles after the final falling edge of a frame. The bench does not poll for the strobe at a fixed edge. It counts strobes during a settle window of 30 cycles after each frame, which is longer than that latency, and shorter than the gap that would trigger the next one. It then compares the count, byte and flag on a falling system edge. The timeout case waits three timeout periods before checking that no strobe appeared, so the check is independent of the exact expiry cycle.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int DATA_BITS  = 8;
    localparam int SHIFT_BITS = FRAME_BITS - 1;  // start + data + parity
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef logic [DATA_BITS-1:0] kbd_byte_t;
endpackage

// File: rtl/kbd_line_cond.sv
// Synchronise one asynchronous line and accept a new level only once it
// has persisted for FILT_LEN consecutive system cycles.
module kbd_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int FCW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FCW-1:0]         cnt;
        logic                   level;
    } cond_t;

    cond_t s_d, s_q;
    logic  synced;

    assign synced = s_q.sync[SYNC_STAGES-1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], raw_i};
        if (synced == s_q.level) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == FCW'(FILT_LEN - 1)) begin
            s_d.level = synced;
            s_d.cnt   = '0;
        end else begin
            s_d.cnt = s_q.cnt + FCW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.sync  <= '1;
            s_q.cnt   <= '0;
            s_q.level <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.level;
endmodule

// File: rtl/kbd_edge_det.sv
// Registered high-to-low transition detector on a filtered level.
module kbd_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
        logic fall;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.prev = level_i;
        e_d.fall = e_q.prev & ~level_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q.prev <= 1'b1;
            e_q.fall <= 1'b0;
        end else begin
            e_q <= e_d;
        end
    end

    assign fall_o = e_q.fall;
endmodule

// File: rtl/kbd_frame_asm.sv
// Collect bits on each falling keyboard-clock pulse, check framing and
// parity on the eleventh bit, abandon a stalled frame after a timeout.
module kbd_frame_asm
    import kbd_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic             dat_i,
    output kbd_byte_t        byte_o,
    output logic             valid_o,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [SHIFT_BITS-1:0] sh;
        logic [TW-1:0]         tmr;
        kbd_byte_t             data;
        logic                  valid;
        logic                  err;
    } asm_t;

    asm_t a_d, a_q;

    logic      start_bit;
    logic      par_bit;
    kbd_byte_t pay;
    logic      last_bit;
    logic      bad_start;
    logic      bad_stop;
    logic      bad_par;

    // Shift register holds start in bit 0, payload in 8:1, parity in 9.
    assign start_bit = a_q.sh[0];
    assign pay       = a_q.sh[DATA_BITS:1];
    assign par_bit   = a_q.sh[SHIFT_BITS-1];
    assign last_bit  = (a_q.cnt == CNT_W'(FRAME_BITS - 1));
    assign bad_start = start_bit;
    assign bad_stop  = ~dat_i;
    assign bad_par   = ~(^{pay, par_bit});

    always_comb begin
        a_d       = a_q;
        a_d.valid = 1'b0;
        if (fall_i) begin
            a_d.tmr = '0;
            if (last_bit) begin
                a_d.cnt   = '0;
                a_d.data  = pay;
                a_d.err   = bad_start | bad_stop | bad_par;
                a_d.valid = 1'b1;
                a_d.sh    = '0;
            end else begin
                a_d.sh  = {dat_i, a_q.sh[SHIFT_BITS-1:1]};
                a_d.cnt = a_q.cnt + CNT_W'(1);
            end
        end else if (a_q.cnt != '0) begin
            if (a_q.tmr == TW'(TIMEOUT_CYC - 1)) begin
                a_d.cnt = '0;
                a_d.sh  = '0;
                a_d.tmr = '0;
            end else begin
                a_d.tmr = a_q.tmr + TW'(1);
            end
        end else begin
            a_d.tmr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign byte_o  = a_q.data;
    assign valid_o = a_q.valid;
    assign err_o   = a_q.err;
    assign cnt_o   = a_q.cnt;
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
    import kbd_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       rx_err_o
);
    logic             kclk_lvl;
    logic             kdat_lvl;
    logic             kclk_fall;
    logic [CNT_W-1:0] bit_cnt;
    kbd_byte_t        rx_byte;

    logic [1:0] raw_lines;
    logic [1:0] lvl_lines;

    assign raw_lines = {ps2_dat_i, ps2_clk_i};
    assign kclk_lvl  = lvl_lines[0];
    assign kdat_lvl  = lvl_lines[1];

    for (genvar g = 0; g < 2; g++) begin : g_line
        kbd_line_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_cond (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_lines[g]),
            .level_o(lvl_lines[g])
        );
    end

    kbd_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .level_i(kclk_lvl),
        .fall_o (kclk_fall)
    );

    kbd_frame_asm #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_asm (
        .clk    (clk),
        .rst    (rst),
        .fall_i (kclk_fall),
        .dat_i  (kdat_lvl),
        .byte_o (rx_byte),
        .valid_o(rx_valid_o),
        .err_o  (rx_err_o),
        .cnt_o  (bit_cnt)
    );

    assign rx_byte_o = rx_byte;
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk #(
    parameter int TIMEOUT_CYC = 5000,
    parameter int CW          = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          fall,
    input logic [CW-1:0] cnt,
    input logic          valid,
    input logic          err,
    input logic [7:0]    data
);
    localparam int TW = $clog2(TIMEOUT_CYC + 2);

    logic [TW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst || fall || cnt == '0) begin
            idle_q <= '0;
        end else if (idle_q != '1) begin
            idle_q <= idle_q + TW'(1);
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!valid && !err && data == 8'h00 && cnt == '0));

    p_valid_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(fall));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(10));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_timeout_bound_r8: assert property (@(posedge clk) disable iff (rst)
        idle_q <= TW'(TIMEOUT_CYC));

    p_outputs_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(data) && $stable(err)));
endmodule

bind kbd_frame_rx kbd_frame_rx_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .CW         (kbd_rx_pkg::CNT_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .fall (kclk_fall),
    .cnt  (bit_cnt),
    .valid(rx_valid_o),
    .err  (rx_err_o),
    .data (rx_byte_o)
);

// File: tb/kbd_frame_rx_bench.sv
`timescale 1ns/1ps
module kbd_frame_rx_bench;
    localparam int TOUT = 100;
    localparam int HP   = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_err;

    int n_chk = 0;
    int n_err = 0;
    int vcount = 0;
    logic [7:0] cap_byte = 8'h00;
    logic       cap_err = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kbd_frame_rx #(
        .SYNC_STAGES(2),
        .FILT_LEN   (4),
        .TIMEOUT_CYC(TOUT)
    ) u_kbd_frame_rx (
        .clk       (clk),
        .rst       (rst),
        .ps2_clk_i (kclk),
        .ps2_dat_i (kdat),
        .rx_byte_o (rx_byte),
        .rx_valid_o(rx_valid),
        .rx_err_o  (rx_err)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            vcount   <= vcount + 1;
            cap_byte <= rx_byte;
            cap_err  <= rx_err;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        kdat = b;
        cyc(HP / 2);
        if (glitch) begin
            kclk = 1'b0;
            cyc(2);
            kclk = 1'b1;
            cyc(HP / 2 - 2);
        end else begin
            cyc(HP - HP / 2);
        end
        kclk = 1'b0;
        cyc(HP);
        kclk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic st, input bit pflip,
                              input logic sp, input int gl_idx);
        logic [10:0] fr;
        fr = {sp, (~^b) ^ pflip, b, st};
        for (int i = 0; i < 11; i++) send_bit(fr[i], i == gl_idx);
        kdat = 1'b1;
        cyc(30);
    endtask

    task automatic frame_check(input logic [7:0] b, input logic st, input bit pflip,
                               input logic sp, input int gl_idx, input string req);
        int base;
        logic exp_err;
        base = vcount;
        exp_err = st | ~sp | pflip;
        send_frame(b, st, pflip, sp, gl_idx);
        chk(vcount == base + 1, req, vcount - base, 1);
        chk(rx_byte == b && rx_err == exp_err, req, {rx_byte, 3'b0, rx_err},
            {b, 3'b0, exp_err});
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        // R1: reset state
        chk(rx_byte == 8'h00 && !rx_valid && !rx_err, "R1", {rx_byte, rx_valid, rx_err}, 0);

        // R2/R6: every payload value, well formed
        for (int v = 0; v < 256; v++) frame_check(8'(v), 1'b0, 1'b0, 1'b1, -1, "R2_R6");

        // R9: outputs hold between frames
        cyc(50);
        chk(rx_byte == 8'hFF && !rx_err && !rx_valid, "R9", {rx_byte, rx_err}, {8'hFF, 1'b0});

        // R3: parity errors
        for (int v = 0; v < 256; v += 17) frame_check(8'(v), 1'b0, 1'b1, 1'b1, -1, "R3");
        // R4: start bit errors
        for (int v = 3; v < 256; v += 37) frame_check(8'(v), 1'b1, 1'b0, 1'b1, -1, "R4");
        // R5: stop bit errors
        for (int v = 5; v < 256; v += 41) frame_check(8'(v), 1'b0, 1'b0, 1'b0, -1, "R5");

        // R9: error flag holds until next frame
        cyc(40);
        chk(rx_err == 1'b1 && !rx_valid, "R9", rx_err, 1);

        // R7: glitches on the clock line at several bit positions
        for (int g = 0; g < 11; g += 2) frame_check(8'h5A ^ 8'(g), 1'b0, 1'b0, 1'b1, g, "R7");

        // R8: stalled partial frame is dropped
        begin
            int base;
            base = vcount;
            for (int i = 0; i < 4; i++) send_bit(i == 0 ? 1'b0 : 1'b1, 1'b0);
            kdat = 1'b1;
            cyc(3 * TOUT);
            chk(vcount == base, "R8", vcount - base, 0);
            frame_check(8'hC3, 1'b0, 1'b0, 1'b1, -1, "R8");
        end

        // R1: reset mid frame clears partial frame and outputs
        for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(rx_byte == 8'h00 && !rx_err, "R1", {rx_byte, rx_err}, 0);
        kdat = 1'b1;
        cyc(10);
        frame_check(8'h3C, 1'b0, 1'b0, 1'b1, -1, "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule